// File: doc/BRIEF.md
# I2C Register Transaction Sequencer

This block turns one command into a complete I2C transaction and drives a separate bit-level engine that produces the bus waveforms. A command names one of three operations: probe, read or write. It also carries a 7-bit device address, a register address of zero to four bytes, and a byte count. The sequencer issues the ordered list of engine operations (START, STOP, byte write, byte read) and collects the acknowledge results. Write data comes in on a byte-wide valid/ready stream and read data goes out on another.

A single register access is the same command with an address length of 1 and a byte count of 1. Memories that hold extra address bits in the device-address field are reached through a fold mask. Register-address bits above the configured address length are masked and then ORed into the device address. With this, a 1 KiB memory appears as four 256-byte devices. When a transaction ends, a one-cycle done pulse is raised. The device-absent flag, the address-NACK flag and the count of unacknowledged data bytes are valid from that pulse until the next command.

The engine handshake is a one-cycle `eng_req` pulse that carries the operation. The engine returns `eng_done` for one cycle, with the acknowledge bit it received and the byte it read. Engine operation codes are: 0 START, 1 STOP, 2 write byte, 3 read byte.

Top module: `i2cseq_top`

## Requirements
- R1: Command codes are: 0 probe, 1 read, 2 write, 3 probe. A probe issues START, then a write of {device,0}, then STOP. `st_absent` reports the acknowledge bit received for that byte (1 means no acknowledge).
- R2: A read or write with a non-zero address length, and any write, starts with START and a write of {device,0}. If that byte is not acknowledged, the block issues STOP, ends with `st_absent`=1, and issues nothing more.
- R3: Register-address bytes are written most significant byte first, and only as many as the address length. An address length above REG_BYTES (4) is treated as REG_BYTES.
- R4: If a register-address byte is not acknowledged, the transaction ends at once with `st_addr_nack`=1 and no STOP is issued.
- R5: During a write, each data byte is taken from the write stream in order and written. Each unacknowledged data byte adds one to `fail_cnt` and the transfer continues. STOP follows the last data byte. A byte count of 0 sends STOP right after the addressing.
- R6: A read with a non-zero address length runs the write addressing, then STOP, START and a write of {device,1}, then the data reads.
- R7: A read with address length 0 goes from START straight to a write of {device,1}. The acknowledge of the {device,1} byte is ignored in every read.
- R8: Every data read but the last requests an acknowledge (`eng_nack_out`=0), and the last requests a NACK (`eng_nack_out`=1). STOP follows the reads. Read bytes appear on the read stream in order and are held until accepted.
- R9: The device field sent is device | ((register address >> 8*address length) & fold mask), in both the {device,0} byte and the {device,1} byte.
- R10: While `busy` is high, `cmd_valid` is ignored. `done` pulses for one cycle as `busy` falls, with the final status.
- R11: After reset, `busy`, `done`, `eng_req`, `wr_ready` and `rd_valid` are 0 and `fail_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_op | input | 2 | Operation: 0 probe, 1 read, 2 write, 3 probe |
| cmd_dev | input | 7 | Device address |
| cmd_reg | input | 32 | Register address |
| cmd_alen | input | 3 | Register-address length in bytes |
| cmd_len | input | 8 | Data byte count |
| cmd_mask | input | 7 | Fold mask for overflow address bits |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| st_absent | output | 1 | Device byte not acknowledged |
| st_addr_nack | output | 1 | Register-address byte not acknowledged |
| fail_cnt | output | 8 | Unacknowledged write data bytes |
| wr_data | input | 8 | Write stream data |
| wr_valid | input | 1 | Write stream valid |
| wr_ready | output | 1 | Write stream ready |
| rd_data | output | 8 | Read stream data |
| rd_valid | output | 1 | Read stream valid |
| rd_ready | input | 1 | Read stream ready |
| eng_req | output | 1 | Engine operation request pulse |
| eng_kind | output | 2 | Engine operation: 0 START, 1 STOP, 2 write, 3 read |
| eng_byte | output | 8 | Byte to write |
| eng_nack_out | output | 1 | For reads: send NACK instead of acknowledge |
| eng_done | input | 1 | Engine operation finished |
| eng_nack_in | input | 1 | Acknowledge bit received on a write (1 = NACK) |
| eng_rdata | input | 8 | Byte received on a read |

## Verification
The hardest paths to reach are the error exits in the middle of a transaction. These are an address-byte NACK that ends without STOP, and unacknowledged data bytes that must count up while the transfer goes on. Both depend on which engine write is refused. The bench engine model therefore holds a per-transaction bit pattern that selects the refused write by its position. Each vector then lands on one chosen byte: the device byte, the second address byte, or selected data bytes. The read-phase device byte is also refused on purpose, to show that it is ignored. The read sink holds back ready for two cycles in three, so stalled read bytes must stay held.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;

  localparam logic [1:0] K_START = 2'd0;
  localparam logic [1:0] K_STOP  = 2'd1;
  localparam logic [1:0] K_WRITE = 2'd2;
  localparam logic [1:0] K_READ  = 2'd3;

  localparam logic [1:0] OP_PROBE = 2'd0;
  localparam logic [1:0] OP_READ  = 2'd1;
  localparam logic [1:0] OP_WRITE = 2'd2;

  typedef enum logic [3:0] {
    S_IDLE    = 4'd0,
    S_START1  = 4'd1,
    S_DEVW    = 4'd2,
    S_ADDR    = 4'd3,
    S_MIDSTOP = 4'd4,
    S_START2  = 4'd5,
    S_DEVR    = 4'd6,
    S_RDAT    = 4'd7,
    S_RPUSH   = 4'd8,
    S_WGET    = 4'd9,
    S_WDAT    = 4'd10,
    S_STOP    = 4'd11,
    S_FIN     = 4'd12
  } seq_state_t;

endpackage

// File: rtl/i2cseq_cnt.sv
module i2cseq_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] value
);

  always_ff @(posedge clk) begin
    if (rst) begin
      value <= '0;
    end else if (load) begin
      value <= load_val;
    end else if (dec && (value != '0)) begin
      value <= value - W'(1);
    end
  end

endmodule

// File: rtl/i2cseq_fold.sv
module i2cseq_fold #(
  parameter int REG_BYTES = 4,
  parameter int ALEN_W    = 3,
  localparam int REG_W    = 8 * REG_BYTES
) (
  input  logic [6:0]        dev,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [ALEN_W-1:0] alen,
  input  logic [6:0]        mask,
  output logic [6:0]        dev_eff
);

  logic [6:0] high_bits;

  // Bits above the used address bytes; a full-length address leaves none.
  always_comb begin
    high_bits = 7'(reg_addr >> {alen, 3'b000});
    dev_eff   = dev | (high_bits & mask);
  end

endmodule

// File: rtl/i2cseq_bytesel.sv
module i2cseq_bytesel #(
  parameter int REG_BYTES = 4,
  parameter int IDX_W     = 2,
  localparam int REG_W    = 8 * REG_BYTES
) (
  input  logic [REG_W-1:0] reg_addr,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_out
);

  logic [7:0] lanes [REG_BYTES];

  for (genvar b = 0; b < REG_BYTES; b++) begin : g_lane
    assign lanes[b] = reg_addr[8*b +: 8];
  end

  assign byte_out = lanes[idx];

endmodule

// File: rtl/i2cseq_fsm.sv
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int REG_BYTES = 4,
  parameter int LEN_W     = 8,
  parameter int ALEN_W    = 3,
  localparam int REG_W    = 8 * REG_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [6:0]        cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [ALEN_W-1:0] alen_in,
  input  logic [6:0]        cmd_mask,
  input  logic [6:0]        dev_eff,
  input  logic [7:0]        abyte,
  input  logic [ALEN_W-1:0] acnt,
  input  logic [LEN_W-1:0]  dcnt,
  input  logic              eng_done,
  input  logic              eng_nack_in,
  input  logic [7:0]        eng_rdata,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_ready,
  output logic              accept,
  output logic              a_dec,
  output logic              d_dec,
  output logic [6:0]        dev_q,
  output logic [REG_W-1:0]  reg_q,
  output logic [ALEN_W-1:0] alen_q,
  output logic [6:0]        mask_q,
  output logic              eng_req,
  output logic [1:0]        eng_kind,
  output logic [7:0]        eng_byte,
  output logic              eng_nack_out,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              done,
  output logic              st_absent,
  output logic              st_addr_nack,
  output logic [LEN_W-1:0]  fail_cnt
);

  seq_state_t st, nxt;
  logic [1:0] op_q;
  logic       waiting;
  logic [7:0] wbyte;
  logic [1:0] kind_n;
  logic [7:0] byte_n;
  logic       fire, set_abs, set_an, inc_fail, load_rd;
  logic       is_read, is_probe;
  seq_state_t data_nxt;

  assign is_read  = (op_q == OP_READ);
  assign is_probe = (op_q != OP_READ) && (op_q != OP_WRITE);
  assign accept   = (st == S_IDLE) && cmd_valid;
  assign fire     = waiting && eng_done;
  assign data_nxt = (dcnt == '0) ? S_STOP : S_WGET;

  always_comb begin
    kind_n   = K_WRITE;
    byte_n   = 8'h00;
    nxt      = st;
    set_abs  = 1'b0;
    set_an   = 1'b0;
    inc_fail = 1'b0;
    load_rd  = 1'b0;
    a_dec    = 1'b0;
    d_dec    = 1'b0;
    case (st)
      S_START1: begin
        kind_n = K_START;
        nxt    = (is_read && (alen_q == '0)) ? S_DEVR : S_DEVW;
      end
      S_DEVW: begin
        byte_n = {dev_eff, 1'b0};
        if (eng_nack_in) begin
          set_abs = fire;
          nxt     = S_STOP;
        end else if (is_probe) begin
          nxt = S_STOP;
        end else if (acnt != '0) begin
          nxt = S_ADDR;
        end else begin
          nxt = data_nxt;
        end
      end
      S_ADDR: begin
        byte_n = abyte;
        if (eng_nack_in) begin
          set_an = fire;
          nxt    = S_FIN;
        end else begin
          a_dec = fire;
          if (acnt == ALEN_W'(1)) begin
            nxt = is_read ? S_MIDSTOP : data_nxt;
          end else begin
            nxt = S_ADDR;
          end
        end
      end
      S_MIDSTOP: begin
        kind_n = K_STOP;
        nxt    = S_START2;
      end
      S_START2: begin
        kind_n = K_START;
        nxt    = S_DEVR;
      end
      S_DEVR: begin
        byte_n = {dev_eff, 1'b1};
        nxt    = (dcnt == '0) ? S_STOP : S_RDAT;
      end
      S_RDAT: begin
        kind_n  = K_READ;
        nxt     = S_RPUSH;
        d_dec   = fire;
        load_rd = fire;
      end
      S_WDAT: begin
        byte_n   = wbyte;
        inc_fail = fire && eng_nack_in;
        d_dec    = fire;
        nxt      = (dcnt == LEN_W'(1)) ? S_STOP : S_WGET;
      end
      S_STOP: begin
        kind_n = K_STOP;
        nxt    = S_FIN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= S_IDLE;
      op_q         <= '0;
      dev_q        <= '0;
      reg_q        <= '0;
      alen_q       <= '0;
      mask_q       <= '0;
      waiting      <= 1'b0;
      wbyte        <= '0;
      eng_req      <= 1'b0;
      eng_kind     <= K_START;
      eng_byte     <= '0;
      eng_nack_out <= 1'b0;
      wr_ready     <= 1'b0;
      rd_valid     <= 1'b0;
      rd_data      <= '0;
      busy         <= 1'b0;
      done         <= 1'b0;
      st_absent    <= 1'b0;
      st_addr_nack <= 1'b0;
      fail_cnt     <= '0;
    end else begin
      eng_req <= 1'b0;
      done    <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            op_q         <= cmd_op;
            dev_q        <= cmd_dev;
            reg_q        <= cmd_reg;
            alen_q       <= alen_in;
            mask_q       <= cmd_mask;
            busy         <= 1'b1;
            st_absent    <= 1'b0;
            st_addr_nack <= 1'b0;
            fail_cnt     <= '0;
            waiting      <= 1'b0;
            st           <= S_START1;
          end
        end
        S_WGET: begin
          if (!wr_ready) begin
            wr_ready <= 1'b1;
          end else if (wr_valid) begin
            wr_ready <= 1'b0;
            wbyte    <= wr_data;
            st       <= S_WDAT;
          end
        end
        S_RPUSH: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            st       <= (dcnt == '0) ? S_STOP : S_RDAT;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          busy <= 1'b0;
          st   <= S_IDLE;
        end
        default: begin
          if (!waiting) begin
            eng_req      <= 1'b1;
            waiting      <= 1'b1;
            eng_kind     <= kind_n;
            eng_byte     <= byte_n;
            eng_nack_out <= (dcnt == LEN_W'(1));
          end else if (eng_done) begin
            waiting <= 1'b0;
            st      <= nxt;
            if (set_abs)  st_absent    <= 1'b1;
            if (set_an)   st_addr_nack <= 1'b1;
            if (inc_fail) fail_cnt     <= fail_cnt + LEN_W'(1);
            if (load_rd) begin
              rd_data  <= eng_rdata;
              rd_valid <= 1'b1;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/i2cseq_top.sv
module i2cseq_top #(
  parameter int REG_BYTES = 4,
  parameter int LEN_W     = 8,
  localparam int REG_W    = 8 * REG_BYTES,
  localparam int ALEN_W   = $clog2(REG_BYTES + 1),
  localparam int IDX_W    = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [6:0]        cmd_dev,
  input  logic [REG_W-1:0]  cmd_reg,
  input  logic [ALEN_W-1:0] cmd_alen,
  input  logic [LEN_W-1:0]  cmd_len,
  input  logic [6:0]        cmd_mask,
  output logic              busy,
  output logic              done,
  output logic              st_absent,
  output logic              st_addr_nack,
  output logic [LEN_W-1:0]  fail_cnt,
  input  logic [7:0]        wr_data,
  input  logic              wr_valid,
  output logic              wr_ready,
  output logic [7:0]        rd_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic              eng_req,
  output logic [1:0]        eng_kind,
  output logic [7:0]        eng_byte,
  output logic              eng_nack_out,
  input  logic              eng_done,
  input  logic              eng_nack_in,
  input  logic [7:0]        eng_rdata
);

  logic [ALEN_W-1:0] alen_in, alen_q, acnt;
  logic [LEN_W-1:0]  dcnt;
  logic [6:0]        dev_q, mask_q, dev_eff;
  logic [REG_W-1:0]  reg_q;
  logic [7:0]        abyte;
  logic [IDX_W-1:0]  aidx;
  logic              accept, a_dec, d_dec;

  assign alen_in = (cmd_alen > ALEN_W'(REG_BYTES)) ? ALEN_W'(REG_BYTES) : cmd_alen;
  assign aidx    = IDX_W'(acnt - ALEN_W'(1));

  i2cseq_cnt #(.W(ALEN_W)) acnt_i (
    .clk(clk), .rst(rst), .load(accept), .load_val(alen_in), .dec(a_dec), .value(acnt)
  );

  i2cseq_cnt #(.W(LEN_W)) dcnt_i (
    .clk(clk), .rst(rst), .load(accept), .load_val(cmd_len), .dec(d_dec), .value(dcnt)
  );

  i2cseq_fold #(.REG_BYTES(REG_BYTES), .ALEN_W(ALEN_W)) fold_i (
    .dev(dev_q), .reg_addr(reg_q), .alen(alen_q), .mask(mask_q), .dev_eff(dev_eff)
  );

  i2cseq_bytesel #(.REG_BYTES(REG_BYTES), .IDX_W(IDX_W)) sel_i (
    .reg_addr(reg_q), .idx(aidx), .byte_out(abyte)
  );

  i2cseq_fsm #(.REG_BYTES(REG_BYTES), .LEN_W(LEN_W), .ALEN_W(ALEN_W)) fsm_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .alen_in(alen_in), .cmd_mask(cmd_mask), .dev_eff(dev_eff),
    .abyte(abyte), .acnt(acnt), .dcnt(dcnt), .eng_done(eng_done),
    .eng_nack_in(eng_nack_in), .eng_rdata(eng_rdata), .wr_valid(wr_valid),
    .wr_data(wr_data), .rd_ready(rd_ready), .accept(accept), .a_dec(a_dec),
    .d_dec(d_dec), .dev_q(dev_q), .reg_q(reg_q), .alen_q(alen_q), .mask_q(mask_q),
    .eng_req(eng_req), .eng_kind(eng_kind), .eng_byte(eng_byte),
    .eng_nack_out(eng_nack_out), .wr_ready(wr_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy), .done(done), .st_absent(st_absent),
    .st_addr_nack(st_addr_nack), .fail_cnt(fail_cnt)
  );

endmodule

// File: rtl/i2cseq_chk.sv
module i2cseq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       done,
  input logic       eng_req,
  input logic       wr_ready,
  input logic       wr_valid,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       st_absent,
  input logic       st_addr_nack
);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy has fallen when done is raised
  a_r10_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R10: engine requests only during a transaction, one cycle each
  a_r10_req_busy: assert property (@(posedge clk) disable iff (rst)
    eng_req |-> busy);

  a_r10_req_pulse: assert property (@(posedge clk) disable iff (rst)
    eng_req |=> !eng_req);

  // R5: write stream takes one byte per ready window, only while busy
  a_r5_wr_busy: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> busy);

  a_r5_wr_one: assert property (@(posedge clk) disable iff (rst)
    (wr_ready && wr_valid) |=> !wr_ready);

  // R8: a stalled read byte is held
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R4: the two error exits never coincide
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    done |-> !(st_absent && st_addr_nack));

endmodule

bind i2cseq_top i2cseq_chk chk_i (
  .clk(clk), .rst(rst), .busy(busy), .done(done), .eng_req(eng_req),
  .wr_ready(wr_ready), .wr_valid(wr_valid), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .st_absent(st_absent),
  .st_addr_nack(st_addr_nack)
);

// File: tb/i2cseq_top_tb_top.sv
module i2cseq_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 15;

  typedef struct packed {
    logic [1:0]  op;
    logic [6:0]  dev;
    logic [31:0] rg;
    logic [2:0]  alen;
    logic [7:0]  len;
    logic [6:0]  mask;
    logic [15:0] pat;
    logic        xabs;
    logic        xan;
    logic [7:0]  xfail;
  } vec_t;

  // pat bit k: the k-th engine write of the transaction gets a NACK
  localparam vec_t VECS [NV] = '{
    '{2'd0, 7'h50, 32'h0,        3'd0, 8'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd0, 7'h51, 32'h0,        3'd0, 8'd0, 7'h00, 16'h0001, 1'b1, 1'b0, 8'd0},
    '{2'd2, 7'h50, 32'h1234,     3'd2, 8'd3, 7'h00, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd2, 7'h22, 32'h7,        3'd1, 8'd4, 7'h00, 16'h0028, 1'b0, 1'b0, 8'd2},
    '{2'd2, 7'h3C, 32'h55,       3'd1, 8'd2, 7'h00, 16'h0001, 1'b1, 1'b0, 8'd0},
    '{2'd2, 7'h50, 32'hABCDEF,   3'd3, 8'd2, 7'h00, 16'h0004, 1'b0, 1'b1, 8'd0},
    '{2'd1, 7'h50, 32'h0102,     3'd2, 8'd3, 7'h00, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd1, 7'h48, 32'h0,        3'd0, 8'd2, 7'h00, 16'h0001, 1'b0, 1'b0, 8'd0},
    '{2'd1, 7'h50, 32'h3A5,      3'd1, 8'd1, 7'h03, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd1, 7'h10, 32'hDEADBEEF, 3'd4, 8'd1, 7'h7F, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd2, 7'h61, 32'h0,        3'd0, 8'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd1, 7'h61, 32'h9,        3'd1, 8'd0, 7'h00, 16'h0000, 1'b0, 1'b0, 8'd0},
    '{2'd3, 7'h2A, 32'h0,        3'd0, 8'd0, 7'h00, 16'h0001, 1'b1, 1'b0, 8'd0},
    '{2'd1, 7'h70, 32'h44,       3'd1, 8'd2, 7'h00, 16'h0002, 1'b0, 1'b1, 8'd0},
    '{2'd2, 7'h12, 32'h11223344, 3'd7, 8'd1, 7'h7F, 16'h0000, 1'b0, 1'b0, 8'd0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = '0;
  logic [6:0] cmd_dev = '0, cmd_mask = '0;
  logic [31:0] cmd_reg = '0;
  logic [2:0] cmd_alen = '0;
  logic [7:0] cmd_len = '0;
  logic busy, done, st_absent, st_addr_nack;
  logic [7:0] fail_cnt;
  logic [7:0] wr_data = 8'h30;
  logic wr_valid = 1'b1;
  logic wr_ready;
  logic [7:0] rd_data;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic eng_req;
  logic [1:0] eng_kind;
  logic [7:0] eng_byte;
  logic eng_nack_out;
  logic eng_done = 1'b0, eng_nack_in = 1'b0;
  logic [7:0] eng_rdata = '0;

  i2cseq_top dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_dev(cmd_dev),
    .cmd_reg(cmd_reg), .cmd_alen(cmd_alen), .cmd_len(cmd_len), .cmd_mask(cmd_mask),
    .busy(busy), .done(done), .st_absent(st_absent), .st_addr_nack(st_addr_nack),
    .fail_cnt(fail_cnt), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .eng_req(eng_req),
    .eng_kind(eng_kind), .eng_byte(eng_byte), .eng_nack_out(eng_nack_out),
    .eng_done(eng_done), .eng_nack_in(eng_nack_in), .eng_rdata(eng_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  logic [1:0] lk [64];
  logic [7:0] lb [64];
  logic       ln [64];
  int nlog = 0;
  logic [1:0] ek [64];
  logic [7:0] eb [64];
  logic       en [64];
  int nexp = 0;
  logic [7:0] rgot [64];
  int nrd = 0, xrd = 0;
  logic [15:0] pat_cur = '0;
  int wcnt = 0, rcnt = 0, widx = 0, ndone = 0, cyc = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] k, input logic [7:0] b, input logic n);
    ek[nexp] = k; eb[nexp] = b; en[nexp] = n; nexp++;
  endtask

  task automatic push_reads(input vec_t v);
    for (int j = 0; j < int'(v.len); j++) push(2'd3, 8'h00, (j == int'(v.len) - 1));
    xrd = int'(v.len);
    push(2'd1, 8'h00, 1'b0);
  endtask

  // expected engine sequence, derived from the requirements
  task automatic build_exp(input vec_t v);
    int al, w;
    logic [6:0] df;
    nexp = 0; xrd = 0; w = 0;
    al = (v.alen > 3'd4) ? 4 : int'(v.alen);
    df = v.dev | (7'(v.rg >> (8 * al)) & v.mask);
    push(2'd0, 8'h00, 1'b0);
    if (v.op == 2'd1 && al == 0) begin
      push(2'd2, {df, 1'b1}, 1'b0);
      push_reads(v);
      return;
    end
    push(2'd2, {df, 1'b0}, 1'b0);
    if (v.pat[w]) begin push(2'd1, 8'h00, 1'b0); return; end
    w++;
    if (v.op == 2'd0 || v.op == 2'd3) begin push(2'd1, 8'h00, 1'b0); return; end
    for (int i = al - 1; i >= 0; i--) begin
      push(2'd2, 8'(v.rg >> (8 * i)), 1'b0);
      if (v.pat[w]) return;
      w++;
    end
    if (v.op == 2'd1) begin
      push(2'd1, 8'h00, 1'b0);
      push(2'd0, 8'h00, 1'b0);
      push(2'd2, {df, 1'b1}, 1'b0);
      push_reads(v);
      return;
    end
    for (int j = 0; j < int'(v.len); j++) push(2'd2, 8'h30 + 8'(j), 1'b0);
    push(2'd1, 8'h00, 1'b0);
  endtask

  // bit-level engine model
  initial begin
    forever begin
      @(negedge clk);
      if (eng_req && nlog < 64) begin
        lk[nlog] = eng_kind; lb[nlog] = eng_byte; ln[nlog] = eng_nack_out;
        nlog++;
        @(negedge clk);
        @(negedge clk);
        eng_nack_in = (lk[nlog-1] == 2'd2 && wcnt < 16) ? pat_cur[wcnt] : 1'b0;
        if (lk[nlog-1] == 2'd2) wcnt++;
        eng_rdata = 8'hC0 + 8'(rcnt);
        if (lk[nlog-1] == 2'd3) rcnt++;
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
      end
    end
  end

  // write stream source
  initial begin
    forever begin
      @(negedge clk);
      if (wr_ready) begin
        @(posedge clk);
        #1;
        widx++;
        wr_data = 8'h30 + 8'(widx);
      end
    end
  end

  // read stream sink with stalls
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      rd_ready = (cyc % 3) == 0;
      if (rd_valid && rd_ready && nrd < 64) begin
        rgot[nrd] = rd_data;
        nrd++;
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (done) ndone++;
    end
  end

  task automatic prep(input vec_t v);
    pat_cur = v.pat; wcnt = 0; rcnt = 0; nlog = 0; nrd = 0;
    widx = 0; wr_data = 8'h30;
    build_exp(v);
  endtask

  task automatic issue(input vec_t v);
    @(negedge clk);
    cmd_op = v.op; cmd_dev = v.dev; cmd_reg = v.rg; cmd_alen = v.alen;
    cmd_len = v.len; cmd_mask = v.mask; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 1'b0;
    for (int t = 0; t < 5000; t++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_log(input string tag);
    int bad;
    bad = 0;
    check(nlog == nexp, {tag, " op count"}, nlog, nexp);
    for (int i = 0; i < nexp && i < nlog; i++) begin
      if (lk[i] != ek[i]) bad++;
      else if (ek[i] == 2'd2 && lb[i] != eb[i]) bad++;
      else if (ek[i] == 2'd3 && ln[i] != en[i]) bad++;
    end
    check(bad == 0, {tag, " op sequence"}, bad, 0);
  endtask

  initial begin
    bit seen;
    vec_t v;
    int d0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check(!busy && !done && !eng_req, "R11 reset control", {busy, done, eng_req}, 0);
    check(!wr_ready && !rd_valid && fail_cnt == 0, "R11 reset streams", {wr_ready, rd_valid, fail_cnt}, 0);

    for (int n = 0; n < NV; n++) begin
      string tag;
      v = VECS[n];
      tag = $sformatf("R1/R2/R3/R4/R5/R6/R7/R8/R9 vec%0d", n);
      prep(v);
      issue(v);
      wait_done(seen);
      check(seen, {tag, " done"}, seen, 1);
      check(st_absent == v.xabs, {tag, " absent"}, st_absent, v.xabs);
      check(st_addr_nack == v.xan, {tag, " addr nack"}, st_addr_nack, v.xan);
      check(fail_cnt == v.xfail, {tag, " fail count"}, fail_cnt, v.xfail);
      check_log(tag);
      if (xrd > 0) begin
        int bad;
        bad = 0;
        for (int j = 0; j < xrd && j < nrd; j++) if (rgot[j] != 8'hC0 + 8'(j)) bad++;
        check(nrd == xrd && bad == 0, {tag, " R8 read stream"}, nrd, xrd);
      end
      repeat (3) @(negedge clk);
    end

    // R10: a command presented while busy is ignored
    v = VECS[2];
    prep(v);
    d0 = ndone;
    issue(v);
    repeat (15) @(negedge clk);
    check(busy, "R10 busy mid transfer", busy, 1);
    cmd_op = 2'd0; cmd_dev = 7'h7F; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(seen);
    check(seen && fail_cnt == 0 && !st_absent, "R10 done status", {seen, st_absent}, 2);
    check_log("R10 ignored command");
    repeat (40) @(negedge clk);
    check(nlog == nexp && !busy, "R10 no late start", nlog, nexp);
    check(ndone - d0 == 1, "R10 single done pulse", ndone - d0, 1);

    // R11: reset in the middle of a transfer returns to idle
    prep(VECS[6]);
    issue(VECS[6]);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !rd_valid && !wr_ready, "R11 mid reset", {busy, rd_valid, wr_ready}, 0);
    repeat (20) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule